// File: doc/BRIEF.md
# Receive Data Frame Buffer

This block sits between a serial link receiver and the system side of a chip. The receiver hands it frames one word per cycle. Each word carries start and end markers, and the header fields (channel type and frame size) travel with it. The block decides at the first word of each frame whether the frame is a data frame it should keep. It keeps the frame only if the channel type matches the configured data value and three configuration bits are all set: data enable, receive enable and data FIFO enable. Kept frames are written word by word into a receive FIFO.

The system side sees a ready signal whenever at least one complete frame is waiting. It also sees the head word with its markers, channel type and size, and a count of unread frames. It pulls words with a read strobe. If the FIFO fills while a frame is being stored, the rest of that frame is thrown away. The last word that was stored is marked as the end of the frame, so the truncated frame still reads out as a whole frame. A sticky overflow flag records the event, and an interrupt follows the flag when it is enabled.

Top module: `rx_frame_buf`

## Requirements
- R1: A frame is stored only if, on its start word, the channel type equals DATA_CT (default 4'h4) and data enable, receive enable and FIFO enable are all 1. Its words read out in arrival order with their data and start and end markers intact.
- R2: If any of the three enables is 0 on the start word, the whole frame is dropped. The frame count and the overflow flag are unchanged.
- R3: A frame whose start word carries any channel type other than DATA_CT is dropped. The frame count and the overflow flag are unchanged.
- R4: `rdReady` is 1 exactly when the unread-frame count is non-zero. While it is 1, the outputs show the oldest stored word with its channel type and size.
- R5: `frameCnt` rises by one when a frame's end word is stored, and falls by one when the system side reads a word whose end marker is 1.
- R6: If an accepted frame meets a full FIFO after at least one of its words was stored, the incoming word and the rest of the frame are discarded. The last stored word gets its end marker set to 1, and the frame is counted.
- R7: If the FIFO is full when an accepted frame's start word arrives, the whole frame is discarded, the count is unchanged and the overflow flag is set.
- R8: `ovfFlag` is set by any overflow and stays set until a cycle with `ovfClr` = 1 and no new overflow. An overflow in the same cycle as a clear wins.
- R9: `irq` equals `ovfFlag` when `cfgOvfIrqEn` is 1, and is 0 otherwise.
- R10: After reset `rdReady`, `frameCnt`, `ovfFlag` and `irq` are all 0.
- R11: A read strobe while `rdReady` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgDataEn | input | 1 | Data frame enable |
| cfgRxEn | input | 1 | Receive path enable |
| cfgFifoEn | input | 1 | Data FIFO enable |
| cfgOvfIrqEn | input | 1 | Overflow interrupt enable |
| inValid | input | 1 | Incoming word valid |
| inSof | input | 1 | Incoming word is a frame start |
| inEof | input | 1 | Incoming word is a frame end |
| inChanType | input | CT_W | Header channel type |
| inSize | input | SIZE_W | Header frame size |
| inData | input | DATA_W | Incoming word |
| rdEn | input | 1 | System-side read strobe |
| rdReady | output | 1 | At least one complete frame is stored |
| outData | output | DATA_W | Head word data |
| outSof | output | 1 | Head word is a frame start |
| outEof | output | 1 | Head word is a frame end |
| outChanType | output | CT_W | Head word channel type |
| outSize | output | SIZE_W | Head word frame size |
| frameCnt | output | log2(DEPTH)+1 | Unread complete frames |
| ovfClr | input | 1 | Write-one-to-clear for the overflow flag |
| ovfFlag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest case to reach is truncation. A frame must be partly stored when the FIFO fills, and then the marker has to be patched onto a word that was written in an earlier cycle. A close second is the start word that arrives to a FIFO that is already exactly full. Directed sequences reach both cases: one fills eight entries with a six-word frame followed by a five-word frame, and another fills them with a single eight-word frame, in both cases with reads held off. A long random phase then keeps reads rare so that the FIFO keeps running full against mixed channel types, toggled enables and flag clears. A word-level model in the bench follows every stored word, patch and read.

// File: rtl/rx_frame_pkg.sv
package rx_frame_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic push;      // write incoming word at the tail
    logic patchEof;  // set end marker on the most recently written word
    logic pop;       // retire the head word
  } dpCtrl_t;
endpackage

// File: rtl/rx_frame_dp.sv
module rx_frame_dp
  import rx_frame_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned CT_W   = 4,
  parameter int unsigned SIZE_W = 4,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [DATA_W-1:0] inData,
  input  logic              inSof,
  input  logic              inEof,
  input  logic [CT_W-1:0]   inChanType,
  input  logic [SIZE_W-1:0] inSize,
  output logic              full,
  output logic [CW-1:0]     occupancy,
  output logic [DATA_W-1:0] headData,
  output logic              headSof,
  output logic              headEof,
  output logic [CT_W-1:0]   headChanType,
  output logic [SIZE_W-1:0] headSize
);
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [CT_W-1:0]   ctMem   [DEPTH];
  logic [SIZE_W-1:0] sizeMem [DEPTH];
  logic [DEPTH-1:0]  sofBits;
  logic [DEPTH-1:0]  eofBits;
  logic [AW-1:0]     wrPtr, rdPtr, lastPtr;
  logic [CW-1:0]     occ;

  assign lastPtr   = wrPtr - 1'b1;
  assign full      = (occ == CW'(DEPTH));
  assign occupancy = occ;

  always_ff @(posedge clk) begin
    if (ctl.push) begin
      dataMem[wrPtr] <= inData;
      ctMem[wrPtr]   <= inChanType;
      sizeMem[wrPtr] <= inSize;
    end
  end

  // per-entry marker bits; end marker can be patched after the write
  for (genvar i = 0; i < DEPTH; i++) begin : gMark
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sofBits[i] <= 1'b0;
        eofBits[i] <= 1'b0;
      end else if (ctl.push && wrPtr == AW'(i)) begin
        sofBits[i] <= inSof;
        eofBits[i] <= inEof;
      end else if (ctl.patchEof && lastPtr == AW'(i)) begin
        eofBits[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (ctl.push) wrPtr <= wrPtr + 1'b1;
      if (ctl.pop)  rdPtr <= rdPtr + 1'b1;
      occ <= occ + CW'(ctl.push) - CW'(ctl.pop);
    end
  end

  assign headData     = dataMem[rdPtr];
  assign headSof      = sofBits[rdPtr];
  assign headEof      = eofBits[rdPtr];
  assign headChanType = ctMem[rdPtr];
  assign headSize     = sizeMem[rdPtr];

  // R11
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |-> occ != '0);

  // R6
  patch_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.patchEof |-> (full && !ctl.push));
endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import rx_frame_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned CT_W    = 4,
  parameter int unsigned DATA_CT = 4,
  localparam int unsigned CW     = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgDataEn,
  input  logic            cfgRxEn,
  input  logic            cfgFifoEn,
  input  logic            cfgOvfIrqEn,
  input  logic            inValid,
  input  logic            inSof,
  input  logic            inEof,
  input  logic [CT_W-1:0] inChanType,
  input  logic            rdEn,
  input  logic            ovfClr,
  input  logic            full,
  input  logic            headEof,
  input  logic [CW-1:0]   occupancy,
  output dpCtrl_t         ctl,
  output logic [CW-1:0]   frameCnt,
  output logic            rdReady,
  output logic            ovfFlag,
  output logic            irq
);
  logic startWord, enOk, acceptNow, ovfEvent, incFrame, decFrame;
  logic accepting, storedAny;

  always_comb begin
    startWord    = inValid & inSof;
    enOk         = cfgDataEn & cfgRxEn & cfgFifoEn;
    acceptNow    = startWord ? (enOk && inChanType == CT_W'(DATA_CT))
                             : (inValid & accepting);
    ovfEvent     = acceptNow & full;
    ctl.push     = acceptNow & ~full;
    ctl.patchEof = ovfEvent & ~startWord & storedAny;
    ctl.pop      = rdEn & rdReady;
    incFrame     = (ctl.push & inEof) | ctl.patchEof;
    decFrame     = ctl.pop & headEof;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accepting <= 1'b0;
      storedAny <= 1'b0;
      frameCnt  <= '0;
      ovfFlag   <= 1'b0;
    end else begin
      if (inValid) begin
        accepting <= acceptNow & ~inEof & ~ovfEvent;
        storedAny <= startWord ? ctl.push : (storedAny | ctl.push);
      end
      frameCnt <= frameCnt + CW'(incFrame) - CW'(decFrame);
      if (ovfEvent)    ovfFlag <= 1'b1;
      else if (ovfClr) ovfFlag <= 1'b0;
    end
  end

  assign rdReady = (frameCnt != '0);
  assign irq     = ovfFlag & cfgOvfIrqEn;

  // R5
  frames_within_words_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameCnt <= occupancy);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag);

  // R3
  nondata_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startWord && inChanType != CT_W'(DATA_CT) && !ctl.pop)
      |=> frameCnt == $past(frameCnt));
endmodule

// File: rtl/rx_frame_buf.sv
module rx_frame_buf
  import rx_frame_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned CT_W    = 4,
  parameter int unsigned SIZE_W  = 4,
  parameter int unsigned DATA_CT = 4,
  localparam int unsigned CW     = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgDataEn,
  input  logic              cfgRxEn,
  input  logic              cfgFifoEn,
  input  logic              cfgOvfIrqEn,
  input  logic              inValid,
  input  logic              inSof,
  input  logic              inEof,
  input  logic [CT_W-1:0]   inChanType,
  input  logic [SIZE_W-1:0] inSize,
  input  logic [DATA_W-1:0] inData,
  input  logic              rdEn,
  output logic              rdReady,
  output logic [DATA_W-1:0] outData,
  output logic              outSof,
  output logic              outEof,
  output logic [CT_W-1:0]   outChanType,
  output logic [SIZE_W-1:0] outSize,
  output logic [CW-1:0]     frameCnt,
  input  logic              ovfClr,
  output logic              ovfFlag,
  output logic              irq
);
  dpCtrl_t       ctl;
  logic          full;
  logic [CW-1:0] occupancy;

  rx_frame_ctrl #(.DEPTH(DEPTH), .CT_W(CT_W), .DATA_CT(DATA_CT)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cfgDataEn(cfgDataEn), .cfgRxEn(cfgRxEn), .cfgFifoEn(cfgFifoEn),
    .cfgOvfIrqEn(cfgOvfIrqEn),
    .inValid(inValid), .inSof(inSof), .inEof(inEof), .inChanType(inChanType),
    .rdEn(rdEn), .ovfClr(ovfClr),
    .full(full), .headEof(outEof), .occupancy(occupancy),
    .ctl(ctl), .frameCnt(frameCnt), .rdReady(rdReady),
    .ovfFlag(ovfFlag), .irq(irq)
  );

  rx_frame_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CT_W(CT_W), .SIZE_W(SIZE_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .inData(inData), .inSof(inSof), .inEof(inEof),
    .inChanType(inChanType), .inSize(inSize),
    .full(full), .occupancy(occupancy),
    .headData(outData), .headSof(outSof), .headEof(outEof),
    .headChanType(outChanType), .headSize(outSize)
  );
endmodule

// File: tb/rx_frame_buf_tb_top.sv
module rx_frame_buf_tb_top;
  localparam int DEPTH = 8;
  localparam logic [3:0] DCT = 4'h4;

  typedef struct packed {
    logic [31:0] d; logic s; logic e; logic [3:0] c; logic [3:0] z;
  } wrd_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic dataEn = 1, rxEn = 1, fifoEn = 1, irqEn = 1;
  logic inValid = 0, inSof = 0, inEof = 0, rdEn = 0, ovfClr = 0;
  logic [3:0] inCt = '0, inSz = '0;
  logic [31:0] inData = '0;
  logic rdReady, outSof, outEof, ovfFlag, irq;
  logic [31:0] outData;
  logic [3:0] outCt, outSz, frameCnt;

  int checks = 0, errors = 0;
  bit done = 0;

  wrd_t mq[$];
  int mCnt = 0;
  bit mOvf = 0, mAcc = 0, mStored = 0;

  always #10 clk = ~clk;

  rx_frame_buf dut_i (
    .clk(clk), .rstN(rstN), .cfgDataEn(dataEn), .cfgRxEn(rxEn), .cfgFifoEn(fifoEn),
    .cfgOvfIrqEn(irqEn), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inChanType(inCt), .inSize(inSz), .inData(inData), .rdEn(rdEn),
    .rdReady(rdReady), .outData(outData), .outSof(outSof), .outEof(outEof),
    .outChanType(outCt), .outSize(outSz), .frameCnt(frameCnt),
    .ovfClr(ovfClr), .ovfFlag(ovfFlag), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive after negedge, advance model at posedge, compare at next negedge
  task automatic cycle(input logic v, input logic s, input logic e, input logic [3:0] c,
                       input logic [3:0] z, input logic [31:0] d, input logic rd, input logic clr);
    bit startW, fullNow, acc, push, ovfEv, patch, popNow;
    wrd_t w;
    inValid = v; inSof = s; inEof = e; inCt = c; inSz = z; inData = d; rdEn = rd; ovfClr = clr;
    @(posedge clk);
    startW  = v && s;
    fullNow = (mq.size() == DEPTH);
    popNow  = rd && (mCnt != 0);
    acc     = startW ? (dataEn && rxEn && fifoEn && c == DCT) : (v && mAcc);
    push    = acc && !fullNow;
    ovfEv   = acc && fullNow;
    patch   = ovfEv && !startW && mStored;
    if (patch) mq[mq.size()-1].e = 1'b1;
    if (patch) mCnt++;
    if (popNow) begin
      if (mq[0].e) mCnt--;
      void'(mq.pop_front());
    end
    if (push) begin
      w.d = d; w.s = s; w.e = e; w.c = c; w.z = z;
      mq.push_back(w);
      if (e) mCnt++;
    end
    if (v) begin
      mAcc    = acc && !e && !ovfEv;
      mStored = startW ? push : (mStored || push);
    end
    if (ovfEv) mOvf = 1;
    else if (clr) mOvf = 0;
    @(negedge clk);
    chk(rdReady === (mCnt != 0), "R4 ready", rdReady, mCnt != 0);
    chk(frameCnt === 4'(mCnt), "R5 count", frameCnt, mCnt);
    chk(ovfFlag === mOvf, "R8 ovf", ovfFlag, mOvf);
    chk(irq === (mOvf && irqEn), "R9 irq", irq, mOvf && irqEn);
    if (mCnt != 0) begin
      chk(outData === mq[0].d, "R1 data", outData, mq[0].d);
      chk(outSof === mq[0].s, "R1 sof", outSof, mq[0].s);
      chk(outEof === mq[0].e, "R6 eof", outEof, mq[0].e);
      chk(outCt === mq[0].c, "R4 chantype", outCt, mq[0].c);
      chk(outSz === mq[0].z, "R4 size", outSz, mq[0].z);
    end
  endtask

  task automatic sendFrame(input int len, input logic [3:0] c, input int rdPct, input bit gaps);
    logic [3:0] z = 4'(len);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 4 == 0))
        cycle(0, 0, 0, 0, 0, 0, ($urandom % 100) < rdPct, ($urandom % 20) == 0);
      cycle(1, i == 0, i == len - 1, c, z, $urandom, ($urandom % 100) < rdPct,
            ($urandom % 20) == 0);
    end
  endtask

  task automatic drain();
    while (mCnt != 0) cycle(0, 0, 0, 0, 0, 0, 1, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int seen;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    chk(rdReady === 0, "R10 ready", rdReady, 0);
    chk(frameCnt === 0, "R10 count", frameCnt, 0);
    chk(ovfFlag === 0 && irq === 0, "R10 ovf/irq", {ovfFlag, irq}, 0);

    // R11 read on empty
    cycle(0, 0, 0, 0, 0, 0, 1, 0);
    chk(frameCnt === 0 && rdReady === 0, "R11 empty read", frameCnt, 0);

    // R1 basic frame
    sendFrame(3, DCT, 0, 0);
    chk(frameCnt === 1, "R1 stored", frameCnt, 1);
    drain();

    // R2 enables clear
    dataEn = 0; sendFrame(2, DCT, 0, 0);
    chk(frameCnt === 0, "R2 dataEn", frameCnt, 0);
    dataEn = 1; fifoEn = 0; sendFrame(2, DCT, 0, 0);
    chk(frameCnt === 0, "R2 fifoEn", frameCnt, 0);
    fifoEn = 1; rxEn = 0; sendFrame(2, DCT, 0, 0);
    chk(frameCnt === 0, "R2 rxEn", frameCnt, 0);
    rxEn = 1;

    // R3 non-data channel
    sendFrame(3, 4'h2, 0, 0);
    chk(frameCnt === 0 && ovfFlag === 0, "R3 nondata", frameCnt, 0);

    // R6 truncation: 6 + 5 words into 8 entries
    sendFrame(6, DCT, 0, 0);
    sendFrame(5, DCT, 0, 0);
    chk(frameCnt === 2, "R6 count", frameCnt, 2);
    chk(ovfFlag === 1, "R6 ovf", ovfFlag, 1);
    seen = 0;
    while (mCnt != 0) begin
      seen++;
      if (seen == 8) chk(outEof === 1, "R6 patched eof", outEof, 1);
      cycle(0, 0, 0, 0, 0, 0, 1, 0);
    end
    chk(seen == 8, "R6 words read", seen, 8);

    // R9 mask, then R8 clear
    irqEn = 0;
    cycle(0, 0, 0, 0, 0, 0, 0, 0);
    chk(irq === 0 && ovfFlag === 1, "R9 masked", irq, 0);
    irqEn = 1;
    cycle(0, 0, 0, 0, 0, 0, 0, 1);
    chk(ovfFlag === 0, "R8 clear", ovfFlag, 0);

    // R7 start word into full FIFO
    sendFrame(8, DCT, 0, 0);
    chk(frameCnt === 1 && ovfFlag === 0, "R7 exact fill", frameCnt, 1);
    sendFrame(3, DCT, 0, 0);
    chk(frameCnt === 1, "R7 count", frameCnt, 1);
    chk(ovfFlag === 1, "R7 ovf", ovfFlag, 1);
    drain();
    chk(rdReady === 0, "R7 nothing extra", rdReady, 0);
    cycle(0, 0, 0, 0, 0, 0, 0, 1);

    // random phase
    for (int f = 0; f < 500; f++) begin
      logic [3:0] c;
      c = ($urandom % 4 == 0) ? 4'(DCT + 1 + ($urandom % 15)) : DCT;
      dataEn = ($urandom % 12) != 0;
      irqEn  = ($urandom % 3) != 0;
      sendFrame(1 + ($urandom % 6), c, (f % 100 < 50) ? 15 : 60, 1);
    end
    dataEn = 1;
    drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule